// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This controller moves a small microcontroller between a running state and two low-power states. In the light one (sleep) the oscillator keeps running and only the CPU and peripheral clock is gated off. In the deep one (subsleep) the oscillator is stopped as well. The CPU asks for a transition with a one-cycle sleep-instruction strobe. A configuration bit picks the low-power target. When direct transition is requested and allowed, the block instead stays active and adopts a newly selected clock divider value at once.

The block leaves a low-power state in one of two ways. The first is an enabled, unmasked interrupt request. Leaving subsleep this way first restarts the oscillator and waits a programmable stabilization time. The second is the external reset pin, which holds the internal reset for a fixed stabilization count after the pin is released. Two pulse outputs tell the CPU when to begin interrupt or reset exception handling. The global mask bit is captured when a low-power state is entered. If it was set at that moment, no interrupt can wake the block, and only the reset pin brings it back.

States: `PM_ACTIVE`, `PM_SLEEP`, `PM_SUBSLEEP`, `PM_WAKE_WAIT` (oscillator restarting), `PM_RST_HOLD` (pin low), `PM_RST_STAB` (reset stabilization).

Transitions:
- ACTIVE to ACTIVE: direct transition.
- ACTIVE to SLEEP or SUBSLEEP: plain or fallback entry.
- SLEEP to ACTIVE: interrupt wake.
- SUBSLEEP to WAKE_WAIT: interrupt wake.
- WAKE_WAIT to ACTIVE: wait expired.
- Any state to RST_HOLD: pin low.
- RST_HOLD to RST_STAB: pin high.
- RST_STAB to ACTIVE: count expired.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `por_n` is low, `int_rst_o`=1, `osc_run_o`=1, `clk_gate_o`=1, both exception pulses are 0 and `div_o`=0. After `por_n` rises with the pin high, `int_rst_o` stays 1 for 256 cycles. It is then 0 and `rst_exc_o` pulses in the same cycle.
- R2: With `sub_sel_i`=0, a sleep strobe in the active state with no successful direct transition enters sleep. The next cycle shows `osc_run_o`=1 and `clk_gate_o`=0.
- R3: With `sub_sel_i`=1, the same strobe enters subsleep. The next cycle shows `osc_run_o`=0 and `clk_gate_o`=0.
- R4: In subsleep, a wake request brings `osc_run_o` to 1 in the next cycle. `clk_gate_o` stays 0 for 8<<`stby_sel_i` cycles in total, counted only while the oscillator runs. The block then returns to active with a one-cycle `irq_exc_o` pulse.
- R5: In sleep, a wake request returns the block to active in the next cycle, with `clk_gate_o`=1 and a one-cycle `irq_exc_o` pulse.
- R6: A wake request exists only when `irq_mask_i`=0 and some bit i has both `irq_req_i[i]`=1 and `irq_en_i[i]`=1. A request from a disabled source, or any request while the mask is 1, leaves sleep or subsleep unchanged.
- R7: `div_o` loads `div_sel_i` only on a sleep strobe accepted in the active state. At all other times it holds its value.
- R8: A sleep strobe with `dt_en_i`=1, `dt_irq_en_i`=1 and `irq_mask_i`=0 keeps the block active. The next cycle shows the new `div_o` and a one-cycle `irq_exc_o` pulse.
- R9: A sleep strobe with `dt_en_i`=1 but `dt_irq_en_i`=0 enters sleep or subsleep, as `sub_sel_i` selects.
- R10: If `irq_mask_i`=1 when a low-power state is entered, including a direct-transition attempt, no interrupt wakes the block, even after the mask is cleared. Only the reset pin exits.
- R11: Driving `pin_rst_n_i` low in any state gives `int_rst_o`=1, `osc_run_o`=1 and `clk_gate_o`=1 in the next cycle. After the pin rises, the R1 release timing applies.
- R12: When the reset pin is low in the same cycle as a wake request, reset wins and `irq_exc_o` stays 0.
- R13: `irq_exc_o` and `rst_exc_o` are never 1 together, and `clk_gate_o`=1 only while `osc_run_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pin_rst_n_i | input | 1 | External reset pin, active low |
| sleep_i | input | 1 | Sleep-instruction strobe, one cycle |
| sub_sel_i | input | 1 | Low-power target: 0 sleep, 1 subsleep |
| irq_mask_i | input | 1 | Global interrupt mask, 1 masks |
| irq_req_i | input | NSRC | Per-source interrupt requests |
| irq_en_i | input | NSRC | Per-source interrupt enables |
| dt_en_i | input | 1 | Direct-transition enable |
| dt_irq_en_i | input | 1 | Direct-transition interrupt enable |
| stby_sel_i | input | 3 | Standby wait select, wait = 8<<value cycles |
| div_sel_i | input | 3 | Requested active clock divider value |
| osc_run_o | output | 1 | Oscillator run enable |
| clk_gate_o | output | 1 | CPU/peripheral clock enable |
| div_o | output | 3 | Active clock divider value in effect |
| int_rst_o | output | 1 | Internal reset |
| irq_exc_o | output | 1 | Start interrupt exception handling pulse |
| rst_exc_o | output | 1 | Start reset exception handling pulse |

## Verification
A reset-pin assertion and an interrupt wake can land on the same clock edge, and that edge decides the state. The bench provokes this by driving the pin low and raising an enabled, unmasked request on the same falling edge while the block is in subsleep. It does the same during a running wake wait. The outcome counts as correct when the following cycle shows the internal reset asserted with no interrupt exception pulse, and the later release still takes exactly the full stabilization count with the request still present.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int SEL_W = 3;
    localparam int DIV_W = 3;

    typedef enum logic [2:0] {
        PM_ACTIVE    = 3'd0,
        PM_SLEEP     = 3'd1,
        PM_SUBSLEEP  = 3'd2,
        PM_WAKE_WAIT = 3'd3,
        PM_RST_HOLD  = 3'd4,
        PM_RST_STAB  = 3'd5
    } pm_state_e;
endpackage

// File: rtl/pmc_wake_detect.sv
module pmc_wake_detect #(
    parameter int NSRC = 8
) (
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] en_i,
    input  logic            mask_i,
    input  logic            lock_i,
    output logic            wake_o
);
    logic [NSRC-1:0] hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = req_i[g] & en_i[g];
    end

    // A locked entry ignores every interrupt until a reset (R10)
    assign wake_o = !mask_i && !lock_i && (|hit);
endmodule

// File: rtl/pmc_wait_ctr.sv
module pmc_wait_ctr #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          run_i,
    output logic          last_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign last_o = (cnt_q == CW'(1));

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i))); // R4
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int NSRC        = 8,
    parameter int STBY_BASE   = 8,
    parameter int STAB_CYCLES = 256
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             pin_rst_n_i,
    input  logic             sleep_i,
    input  logic             sub_sel_i,
    input  logic             irq_mask_i,
    input  logic [NSRC-1:0]  irq_req_i,
    input  logic [NSRC-1:0]  irq_en_i,
    input  logic             dt_en_i,
    input  logic             dt_irq_en_i,
    input  logic [SEL_W-1:0] stby_sel_i,
    input  logic [DIV_W-1:0] div_sel_i,
    output logic             osc_run_o,
    output logic             clk_gate_o,
    output logic [DIV_W-1:0] div_o,
    output logic             int_rst_o,
    output logic             irq_exc_o,
    output logic             rst_exc_o
);
    localparam int STBY_MAX = STBY_BASE << ((1 << SEL_W) - 1);
    localparam int MAXC     = (STBY_MAX > STAB_CYCLES) ? STBY_MAX : STAB_CYCLES;
    localparam int CW       = $clog2(MAXC + 1);

    pm_state_e        state_q, state_d;
    logic             irq_go, rst_go;
    logic             irq_exc_q, rst_exc_q;
    logic [DIV_W-1:0] div_q;
    logic             lock_q;
    logic             wake;
    logic             cnt_last;
    logic             accept;
    logic             ld_stby, ld_stab;
    logic [CW-1:0]    ld_val;

    pmc_wake_detect #(.NSRC(NSRC)) u_wake (
        .req_i  (irq_req_i),
        .en_i   (irq_en_i),
        .mask_i (irq_mask_i),
        .lock_i (lock_q),
        .wake_o (wake)
    );

    assign ld_stby = (state_q == PM_SUBSLEEP) && (state_d == PM_WAKE_WAIT);
    assign ld_stab = (state_q == PM_RST_HOLD) && (state_d == PM_RST_STAB);
    assign ld_val  = ld_stby ? (CW'(STBY_BASE) << stby_sel_i) : CW'(STAB_CYCLES);

    pmc_wait_ctr #(.CW(CW)) u_ctr (
        .clk        (clk),
        .rst_n      (por_n),
        .load_i     (ld_stby || ld_stab),
        .load_val_i (ld_val),
        .run_i      (osc_run_o),
        .last_o     (cnt_last)
    );

    assign accept = pin_rst_n_i && (state_q == PM_ACTIVE) && sleep_i;

    // next state: the reset pin is examined before any wake source (R12)
    always_comb begin
        state_d = state_q;
        irq_go  = 1'b0;
        rst_go  = 1'b0;
        if (!pin_rst_n_i) begin
            state_d = PM_RST_HOLD;
        end else begin
            unique case (state_q)
                PM_ACTIVE: begin
                    if (sleep_i) begin
                        if (dt_en_i && dt_irq_en_i && !irq_mask_i) begin
                            state_d = PM_ACTIVE;
                            irq_go  = 1'b1;
                        end else begin
                            state_d = sub_sel_i ? PM_SUBSLEEP : PM_SLEEP;
                        end
                    end
                end
                PM_SLEEP: begin
                    if (wake) begin
                        state_d = PM_ACTIVE;
                        irq_go  = 1'b1;
                    end
                end
                PM_SUBSLEEP: begin
                    if (wake) state_d = PM_WAKE_WAIT;
                end
                PM_WAKE_WAIT: begin
                    if (cnt_last) begin
                        state_d = PM_ACTIVE;
                        irq_go  = 1'b1;
                    end
                end
                PM_RST_HOLD: begin
                    state_d = PM_RST_STAB;
                end
                PM_RST_STAB: begin
                    if (cnt_last) begin
                        state_d = PM_ACTIVE;
                        rst_go  = 1'b1;
                    end
                end
                default: state_d = PM_RST_HOLD;
            endcase
        end
    end

    // state register and the registers that travel with it
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q   <= PM_RST_HOLD;
            irq_exc_q <= 1'b0;
            rst_exc_q <= 1'b0;
            div_q     <= '0;
            lock_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            irq_exc_q <= irq_go;
            rst_exc_q <= rst_go;
            if (accept) begin
                div_q  <= div_sel_i;
                lock_q <= irq_mask_i;
            end else if (!pin_rst_n_i) begin
                lock_q <= 1'b0;
            end
        end
    end

    // outputs decoded from the current state
    always_comb begin
        osc_run_o  = 1'b1;
        clk_gate_o = 1'b1;
        int_rst_o  = 1'b0;
        unique case (state_q)
            PM_ACTIVE:    ;
            PM_SLEEP:     clk_gate_o = 1'b0;
            PM_SUBSLEEP: begin
                osc_run_o  = 1'b0;
                clk_gate_o = 1'b0;
            end
            PM_WAKE_WAIT: clk_gate_o = 1'b0;
            PM_RST_HOLD:  int_rst_o  = 1'b1;
            PM_RST_STAB:  int_rst_o  = 1'b1;
            default:      int_rst_o  = 1'b1;
        endcase
    end

    assign div_o     = div_q;
    assign irq_exc_o = irq_exc_q;
    assign rst_exc_o = rst_exc_q;

    AST_RST_PRIORITY: assert property (@(posedge clk) disable iff (!por_n)
        !pin_rst_n_i |=> (int_rst_o && !irq_exc_o)); // R12
    AST_MASK_NO_WAKE: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == PM_SUBSLEEP && irq_mask_i && pin_rst_n_i) |=> !osc_run_o); // R6
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == PM_SLEEP && lock_q && pin_rst_n_i) |=> !clk_gate_o); // R10
    AST_EXC_EXCL: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({irq_exc_o, rst_exc_o})); // R13
    AST_GATE_NEEDS_OSC: assert property (@(posedge clk) disable iff (!por_n)
        clk_gate_o |-> osc_run_o); // R13
    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        !(state_q == PM_ACTIVE && sleep_i && pin_rst_n_i) |=> $stable(div_o)); // R7
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 8;
    localparam int STAB       = 256;

    logic            clk = 1'b0;
    logic            por_n, pin_rst_n, sleep, sub_sel, mask, dt_en, dt_irq_en;
    logic [NSRC-1:0] req, en;
    logic [2:0]      stby_sel, div_sel;
    logic            osc_run, clk_gate, int_rst, irq_exc, rst_exc;
    logic [2:0]      div_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    pwr_mode_ctrl #(.NSRC(NSRC)) dut_i (
        .clk(clk), .por_n(por_n), .pin_rst_n_i(pin_rst_n), .sleep_i(sleep),
        .sub_sel_i(sub_sel), .irq_mask_i(mask), .irq_req_i(req), .irq_en_i(en),
        .dt_en_i(dt_en), .dt_irq_en_i(dt_irq_en), .stby_sel_i(stby_sel),
        .div_sel_i(div_sel), .osc_run_o(osc_run), .clk_gate_o(clk_gate),
        .div_o(div_o), .int_rst_o(int_rst), .irq_exc_o(irq_exc), .rst_exc_o(rst_exc)
    );

    function automatic int exp_wait(input logic [2:0] sel);
        return 8 << sel;
    endfunction

    function automatic bit exp_wake(input logic [NSRC-1:0] r, input logic [NSRC-1:0] e,
                                    input logic m);
        return !m && ((r & e) != '0);
    endfunction

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // counts cycles until the block is active and out of reset
    task automatic run_to_active(output int n, output bit first_osc);
        n = 0;
        first_osc = 1'b0;
        do begin
            tick();
            n++;
            if (n == 1) first_osc = osc_run;
        end while (!(clk_gate && !int_rst) && n < 4000);
    endtask

    task automatic sleep_pulse();
        sleep = 1'b1;
        tick();
        sleep = 1'b0;
    endtask

    task automatic reset_cycle(input string rq);
        int n;
        bit fo;
        pin_rst_n = 1'b1;
        run_to_active(n, fo);
        check(n == STAB + 1, rq, n, STAB + 1);
        check(rst_exc == 1'b1, rq, rst_exc, 1);
        tick();
        check(rst_exc == 1'b0 && irq_exc == 1'b0, "R13", rst_exc, 0);
    endtask

    task automatic wake_sub(input logic [2:0] sel, input string rq);
        int n;
        bit fo;
        run_to_active(n, fo);
        check(fo == 1'b1, "R4 osc restart", fo, 1);
        check(n == exp_wait(sel) + 1, rq, n, exp_wait(sel) + 1);
        check(irq_exc == 1'b1, rq, irq_exc, 1);
        req = '0;
        tick();
        check(irq_exc == 1'b0, rq, irq_exc, 0);
    endtask

    initial begin
        int n;
        bit fo;
        void'($urandom(32'd1234));
        por_n = 1'b0; pin_rst_n = 1'b1; sleep = 1'b0; sub_sel = 1'b0; mask = 1'b0;
        dt_en = 1'b0; dt_irq_en = 1'b0; req = '0; en = '0; stby_sel = '0; div_sel = '0;
        repeat (3) tick();
        // R1 reset state
        check(int_rst && osc_run && clk_gate, "R1 reset outputs", {int_rst, osc_run, clk_gate}, 7);
        check(!irq_exc && !rst_exc && div_o == 3'd0, "R1 pulses/div", {irq_exc, rst_exc, div_o}, 0);
        por_n = 1'b1;
        reset_cycle("R1 release");

        // R7 divider holds without a sleep strobe
        div_sel = 3'd3;
        repeat (3) tick();
        check(div_o == 3'd0, "R7 hold", div_o, 0);

        // R2 sleep, R5 wake from sleep
        sub_sel = 1'b0;
        sleep_pulse();
        check(osc_run == 1'b1 && clk_gate == 1'b0, "R2 sleep", {osc_run, clk_gate}, 2);
        check(div_o == 3'd3, "R7 load", div_o, 3);
        en = 8'h01; req = 8'h01;
        tick();
        check(clk_gate == 1'b1 && irq_exc == 1'b1, "R5 wake", {clk_gate, irq_exc}, 3);
        req = '0;
        tick();
        check(irq_exc == 1'b0, "R5 pulse", irq_exc, 0);

        // R3 subsleep, R6 disabled source and mask, R4 timed wake
        sub_sel = 1'b1; stby_sel = 3'd2; en = 8'h01;
        sleep_pulse();
        check(osc_run == 1'b0 && clk_gate == 1'b0, "R3 subsleep", {osc_run, clk_gate}, 0);
        req = 8'h02;
        repeat (6) tick();
        check(osc_run == 1'b0, "R6 disabled source", osc_run, 0);
        mask = 1'b1; req = 8'h01;
        repeat (6) tick();
        check(osc_run == 1'b0, "R6 masked", osc_run, 0);
        mask = 1'b0;
        wake_sub(3'd2, "R4 wait sel2");

        // R8 direct transition
        div_sel = 3'd5; dt_en = 1'b1; dt_irq_en = 1'b1;
        sleep_pulse();
        check(clk_gate && irq_exc, "R8 stays active", {clk_gate, irq_exc}, 3);
        check(div_o == 3'd5, "R8 new divider", div_o, 5);
        tick();
        check(irq_exc == 1'b0, "R8 pulse", irq_exc, 0);

        // R9 fallback when direct-transition interrupt disabled
        dt_irq_en = 1'b0; sub_sel = 1'b0; div_sel = 3'd6;
        sleep_pulse();
        check(osc_run == 1'b1 && clk_gate == 1'b0, "R9 fallback sleep", {osc_run, clk_gate}, 2);
        check(div_o == 3'd6, "R7 fallback load", div_o, 6);
        req = 8'h01;
        tick();
        check(clk_gate && irq_exc, "R5 wake after R9", {clk_gate, irq_exc}, 3);
        req = '0;
        tick();

        // R10 masked direct attempt locks; R11 reset exits
        dt_irq_en = 1'b1; mask = 1'b1; sub_sel = 1'b1;
        sleep_pulse();
        check(osc_run == 1'b0 && clk_gate == 1'b0, "R10 entered subsleep", {osc_run, clk_gate}, 0);
        mask = 1'b0; req = 8'h01; en = 8'h01;
        repeat (30) tick();
        check(osc_run == 1'b0 && clk_gate == 1'b0, "R10 locked", {osc_run, clk_gate}, 0);
        pin_rst_n = 1'b0;
        tick();
        check(int_rst && osc_run && clk_gate, "R11 pin low", {int_rst, osc_run, clk_gate}, 7);
        req = '0;
        repeat (3) tick();
        reset_cycle("R11 release");

        // R10 locked plain sleep as well
        dt_en = 1'b0; mask = 1'b1; sub_sel = 1'b0;
        sleep_pulse();
        mask = 1'b0; req = 8'h01;
        repeat (10) tick();
        check(clk_gate == 1'b0, "R10 locked sleep", clk_gate, 0);
        pin_rst_n = 1'b0;
        tick();
        req = '0;
        reset_cycle("R11 release from sleep");

        // R12 reset and wake in the same cycle, in subsleep
        sub_sel = 1'b1;
        sleep_pulse();
        req = 8'h01; pin_rst_n = 1'b0;
        tick();
        check(int_rst == 1'b1 && irq_exc == 1'b0, "R12 subsleep", {int_rst, irq_exc}, 2);
        tick();
        check(irq_exc == 1'b0, "R12 no pulse", irq_exc, 0);
        reset_cycle("R12 release with request held");
        req = '0;
        tick();

        // R12 reset during a running wake wait
        stby_sel = 3'd7;
        sleep_pulse();
        req = 8'h01;
        repeat (10) tick();
        check(osc_run == 1'b1 && clk_gate == 1'b0, "R4 waiting", {osc_run, clk_gate}, 2);
        pin_rst_n = 1'b0;
        tick();
        check(int_rst == 1'b1 && irq_exc == 1'b0, "R12 wake wait", {int_rst, irq_exc}, 2);
        req = '0;
        reset_cycle("R11 release after wait");

        // random configurations
        for (int it = 0; it < 14; it++) begin
            logic [2:0]      s, d;
            logic [NSRC-1:0] r, e;
            logic            m;
            s = 3'($urandom % 8);
            d = 3'($urandom % 8);
            r = NSRC'($urandom);
            e = NSRC'($urandom);
            m = 1'($urandom % 2);
            stby_sel = s; div_sel = d; sub_sel = 1'b1; mask = 1'b0; req = '0;
            sleep_pulse();
            check(div_o == d, "R7 random load", div_o, d);
            check(osc_run == 1'b0, "R3 random entry", osc_run, 0);
            req = r; en = e; mask = m;
            if (exp_wake(r, e, m)) begin
                wake_sub(s, "R4 random wait");
            end else begin
                repeat (12) tick();
                check(osc_run == 1'b0 && clk_gate == 1'b0, "R6 random no wake", {osc_run, clk_gate}, 0);
                req = 8'h80; en = 8'h80; mask = 1'b0;
                wake_sub(s, "R4 random late wait");
            end
            div_sel = 3'($urandom % 8);
            repeat (2) tick();
            check(div_o == d, "R7 random hold", div_o, d);
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait (cycles >= 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule